// File: doc/BRIEF.md
# Sliding-Window 3x3 Convolution Row Engine

This block convolves one channel of a feature map with a fixed 3x3 weight kernel. Width and height are run-time settings taken when `start` is accepted. For each output row the engine fetches the three input rows it needs into an on-chip row store, one element per memory request. Rows that fall above the top edge or below the bottom edge are never fetched and read back as zero. A 3x3 register window then walks across the stored rows one column per cycle, with one column of zero padding at each side. It multiplies the window by the nine weights, sums the products in a wide accumulator and saturates the sum into an output row store.

Once a row is complete it is written back through a write port with a valid/ready handshake, and the engine moves on to the next output row. The output has the same dimensions as the input (stride 1, one element of padding on every border). A kernel smaller than 3x3 is run by loading zero into the unused outer weights. Addresses are linear: element (row r, column c) sits at `r*width + c`, in the input space for reads and in the output space for writes.

Top module: `conv3_row_engine`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_err`, `rd_req_valid` and `wr_valid` are all low.
- R2: Output (r,c) equals the sum over i,j in 0..2 of w[i*3+j]*x[r+i-1][c+j-1], where an x outside the map is zero. w[k] is the signed 16-bit field `kernel_in[16*k+15:16*k]`, i selects the kernel row (0 = top) and j the kernel column (0 = left). Input element (r,c) is read from address r*width+c, and the output is written to the same address in the output space.
- R3: A sum above 32767 is written as 32767 and a sum below -32768 is written as -32768; no intermediate sum wraps.
- R4: With every weight zero except the centre weight w[4], each output equals the input element at the same position times w[4] (the smaller-kernel case).
- R5: Only rows inside the map are read. For each output row, exactly `width` reads are made for each of rows r-1, r, r+1 that exist, and no read address reaches width*height.
- R6: No read request is outstanding while results are being written. Within a run, output addresses are written in strictly ascending order, one row after the three rows it depends on have been loaded.
- R7: `rd_req_valid` and `wr_valid`, once raised, stay high with stable address (and write data) until the matching ready is seen. Results stay correct under arbitrary ready and response stalls.
- R8: A start with width 0, width above 30, or height 0 is refused. `cfg_err` rises, `busy` stays low and no read is made. The next accepted start clears `cfg_err`.
- R9: `done` is high for exactly one cycle, in the cycle after the final write handshake, and `busy` is low in that cycle.
- R10: The width, height and weights are captured when start is accepted; changing those inputs while the engine is busy has no effect on the results.
- R11: A `start` pulse while the engine is busy is ignored: the run is neither restarted nor repeated, and only one `done` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration (ignored while busy) |
| cfg_width | input | 6 | Map width in elements, 1..30 |
| cfg_height | input | 8 | Map height in rows, 1..255 |
| kernel_in | input | 144 | Nine signed 16-bit weights, tap k = row*3+col at bits 16k+15:16k |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last output is written |
| cfg_err | output | 1 | Last start was refused for a bad size |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 16 | Input element address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 16 | Signed input element |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 16 | Output element address |
| wr_data | output | 16 | Signed saturated result |

## Verification
The assertions assume that the memory returns exactly one `rd_rsp_valid` for each accepted read, never before the request is accepted, and never while another response is pending. They also assume that `rst_n` is asserted at time zero. The bench memory model tracks a single pending request and presents its response only after acceptance, with random delay. Ready signals are random but are only changed on the falling edge, so the handshake rules the engine must honour are exercised without the bench ever violating what the assertions take for granted.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int KDIM  = 3;
  localparam int KTAPS = KDIM * KDIM;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_RREQ,
    ST_RRSP,
    ST_SLIDE,
    ST_DRAIN,
    ST_FLUSH,
    ST_FIN
  } cv_state_e;
endpackage

// File: rtl/conv3_rowbuf.sv
module conv3_rowbuf #(
  parameter int DATA_W  = 16,
  parameter int ROW_CAP = 32,
  parameter int CW      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mark_en,
  input  logic [1:0]           mark_slot,
  input  logic                 mark_val,
  input  logic                 wr_en,
  input  logic [1:0]           wr_slot,
  input  logic [CW-1:0]        wr_col,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CW-1:0]        rd_k,
  input  logic [CW-1:0]        width,
  output logic [3*DATA_W-1:0]  col_out
);
  localparam int IW = $clog2(ROW_CAP);

  logic [DATA_W-1:0] mem_q [3][ROW_CAP];
  logic [2:0]        vld_q;
  logic [IW-1:0]     wpos;
  logic [IW-1:0]     rpos;
  logic              pad_col;

  assign wpos    = IW'(wr_col + CW'(1));
  assign rpos    = IW'(rd_k);
  assign pad_col = (rd_k == '0) || (rd_k > width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (mark_en) begin
      vld_q[mark_slot] <= mark_val;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_slot][wpos] <= wr_data;
    end
  end

  for (genvar s = 0; s < 3; s++) begin : g_slot
    assign col_out[s*DATA_W +: DATA_W] =
      (pad_col || !vld_q[s]) ? '0 : mem_q[s][rpos];
  end

endmodule

// File: rtl/conv3_window.sv
module conv3_window
  import conv3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 36,
  parameter int CW     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [3*DATA_W-1:0]      col_in,
  input  logic                     tag_vld,
  input  logic [CW-1:0]            tag_idx,
  input  logic [KTAPS*DATA_W-1:0]  wts,
  output logic                     res_vld,
  output logic [CW-1:0]            res_idx,
  output logic [DATA_W-1:0]        res_data
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [DATA_W-1:0]   win_q [KTAPS];
  logic signed [2*DATA_W-1:0] prod  [KTAPS];
  logic signed [ACC_W-1:0]    acc;

  always_ff @(posedge clk) begin
    if (shift_en) begin
      for (int i = 0; i < KDIM; i++) begin
        win_q[i*KDIM+0] <= win_q[i*KDIM+1];
        win_q[i*KDIM+1] <= win_q[i*KDIM+2];
        win_q[i*KDIM+2] <= $signed(col_in[i*DATA_W +: DATA_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_idx <= '0;
    end else begin
      res_vld <= shift_en && tag_vld;
      res_idx <= tag_idx;
    end
  end

  for (genvar t = 0; t < KTAPS; t++) begin : g_tap
    assign prod[t] = win_q[t] * $signed(wts[t*DATA_W +: DATA_W]);
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < KTAPS; t++) begin
      acc = acc + ACC_W'(prod[t]);
    end
  end

  always_comb begin
    if (acc > SAT_HI)      res_data = SAT_HI[DATA_W-1:0];
    else if (acc < SAT_LO) res_data = SAT_LO[DATA_W-1:0];
    else                   res_data = acc[DATA_W-1:0];
  end

  // R6: results of one pass leave the window in ascending column order
  a_r6_col_order: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && $past(res_vld) |-> res_idx == $past(res_idx) + CW'(1));

endmodule

// File: rtl/conv3_seq.sv
module conv3_seq
  import conv3_pkg::*;
#(
  parameter int ROW_CAP = 32,
  parameter int CW      = 6,
  parameter int HGT_W   = 8,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     cfg_width,
  input  logic [HGT_W-1:0]  cfg_height,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic              wr_ready,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CW-1:0]     out_rd_idx,
  output logic              mark_en,
  output logic [1:0]        mark_slot,
  output logic              mark_val,
  output logic              buf_we,
  output logic [1:0]        buf_slot,
  output logic [CW-1:0]     buf_col,
  output logic              shift_en,
  output logic [CW-1:0]     slide_k,
  output logic              tag_vld,
  output logic [CW-1:0]     tag_idx,
  output logic [CW-1:0]     width_out
);
  localparam int PAD   = 1;
  localparam int MAX_W = ROW_CAP - 2*PAD;

  cv_state_e         state_q, state_n;
  logic [CW-1:0]     width_q, width_n;
  logic [HGT_W-1:0]  height_q, height_n;
  logic [HGT_W-1:0]  orow_q, orow_n;
  logic [1:0]        slot_q, slot_n;
  logic [CW-1:0]     col_q, col_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic              err_q, err_n;

  logic [HGT_W:0]    rsum;
  logic              in_rng;
  logic              last_col, last_k, last_row, bad_cfg;

  assign rsum     = {1'b0, orow_q} + (HGT_W+1)'(slot_q);
  assign in_rng   = (rsum != '0) && (rsum <= {1'b0, height_q});
  assign last_col = (col_q == width_q - CW'(1));
  assign last_k   = (col_q == width_q + CW'(1));
  assign last_row = (orow_q == height_q - HGT_W'(1));
  assign bad_cfg  = (cfg_width == '0) || (cfg_width > CW'(MAX_W)) || (cfg_height == '0);

  always_comb begin
    state_n  = state_q;
    width_n  = width_q;
    height_n = height_q;
    orow_n   = orow_q;
    slot_n   = slot_q;
    col_n    = col_q;
    base_n   = base_q;
    err_n    = err_q;
    accept   = 1'b0;
    mark_en  = 1'b0;
    buf_we   = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (bad_cfg) begin
            err_n = 1'b1;
          end else begin
            accept   = 1'b1;
            err_n    = 1'b0;
            width_n  = cfg_width;
            height_n = cfg_height;
            orow_n   = '0;
            slot_n   = '0;
            state_n  = ST_SEL;
          end
        end
      end
      ST_SEL: begin
        mark_en = 1'b1;
        if (in_rng) begin
          col_n   = '0;
          base_n  = ADDR_W'(rsum - (HGT_W+1)'(1)) * ADDR_W'(width_q);
          state_n = ST_RREQ;
        end else if (slot_q == 2'd2) begin
          col_n   = '0;
          state_n = ST_SLIDE;
        end else begin
          slot_n = slot_q + 2'd1;
        end
      end
      ST_RREQ: begin
        if (rd_req_ready) state_n = ST_RRSP;
      end
      ST_RRSP: begin
        if (rd_rsp_valid) begin
          buf_we = 1'b1;
          if (!last_col) begin
            col_n   = col_q + CW'(1);
            state_n = ST_RREQ;
          end else if (slot_q == 2'd2) begin
            col_n   = '0;
            state_n = ST_SLIDE;
          end else begin
            slot_n  = slot_q + 2'd1;
            state_n = ST_SEL;
          end
        end
      end
      ST_SLIDE: begin
        shift_en = 1'b1;
        if (last_k) state_n = ST_DRAIN;
        else        col_n   = col_q + CW'(1);
      end
      ST_DRAIN: begin
        col_n   = '0;
        base_n  = ADDR_W'(orow_q) * ADDR_W'(width_q);
        state_n = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (wr_ready) begin
          if (!last_col) begin
            col_n = col_q + CW'(1);
          end else if (last_row) begin
            state_n = ST_FIN;
          end else begin
            orow_n  = orow_q + HGT_W'(1);
            slot_n  = '0;
            state_n = ST_SEL;
          end
        end
      end
      ST_FIN: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      width_q  <= '0;
      height_q <= '0;
      orow_q   <= '0;
      slot_q   <= '0;
      col_q    <= '0;
      base_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      width_q  <= width_n;
      height_q <= height_n;
      orow_q   <= orow_n;
      slot_q   <= slot_n;
      col_q    <= col_n;
      base_q   <= base_n;
      err_q    <= err_n;
    end
  end

  assign busy         = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done         = (state_q == ST_FIN);
  assign cfg_err      = err_q;
  assign rd_req_valid = (state_q == ST_RREQ);
  assign rd_req_addr  = base_q + ADDR_W'(col_q);
  assign wr_valid     = (state_q == ST_FLUSH);
  assign wr_addr      = base_q + ADDR_W'(col_q);
  assign out_rd_idx   = col_q;
  assign mark_slot    = slot_q;
  assign mark_val     = in_rng;
  assign buf_slot     = slot_q;
  assign buf_col      = col_q;
  assign slide_k      = col_q;
  assign tag_vld      = (col_q >= CW'(2));
  assign tag_idx      = col_q - CW'(2);
  assign width_out    = width_q;

  // R5: every read address lies inside the configured map
  a_r5_addr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr < ADDR_W'(width_q) * ADDR_W'(height_q));

  // R8: a refused start leaves the engine idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

endmodule

// File: rtl/conv3_row_engine.sv
module conv3_row_engine
  import conv3_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ROW_CAP = 32,
  parameter int HGT_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int ACC_W   = 2*DATA_W + 4,
  parameter int CW      = $clog2(ROW_CAP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CW-1:0]           cfg_width,
  input  logic [HGT_W-1:0]        cfg_height,
  input  logic [KTAPS*DATA_W-1:0] kernel_in,
  output logic                    busy,
  output logic                    done,
  output logic                    cfg_err,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [ADDR_W-1:0]       rd_req_addr,
  input  logic                    rd_rsp_valid,
  input  logic [DATA_W-1:0]       rd_rsp_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [DATA_W-1:0]       wr_data
);
  localparam int IW = $clog2(ROW_CAP);

  logic                    accept;
  logic                    mark_en, mark_val, buf_we, shift_en, tag_vld, res_vld;
  logic [1:0]              mark_slot, buf_slot;
  logic [CW-1:0]           buf_col, slide_k, tag_idx, res_idx, out_rd_idx, width_q;
  logic [3*DATA_W-1:0]     col_bus;
  logic [DATA_W-1:0]       res_data;
  logic [KTAPS*DATA_W-1:0] wts_q;
  logic [DATA_W-1:0]       obuf_q [ROW_CAP];

  conv3_seq #(
    .ROW_CAP(ROW_CAP), .CW(CW), .HGT_W(HGT_W), .ADDR_W(ADDR_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid), .wr_ready(wr_ready),
    .accept(accept), .busy(busy), .done(done), .cfg_err(cfg_err),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .out_rd_idx(out_rd_idx),
    .mark_en(mark_en), .mark_slot(mark_slot), .mark_val(mark_val),
    .buf_we(buf_we), .buf_slot(buf_slot), .buf_col(buf_col),
    .shift_en(shift_en), .slide_k(slide_k), .tag_vld(tag_vld), .tag_idx(tag_idx),
    .width_out(width_q)
  );

  conv3_rowbuf #(
    .DATA_W(DATA_W), .ROW_CAP(ROW_CAP), .CW(CW)
  ) rowbuf_i (
    .clk(clk), .rst_n(rst_n),
    .mark_en(mark_en), .mark_slot(mark_slot), .mark_val(mark_val),
    .wr_en(buf_we), .wr_slot(buf_slot), .wr_col(buf_col), .wr_data(rd_rsp_data),
    .rd_k(slide_k), .width(width_q), .col_out(col_bus)
  );

  conv3_window #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .CW(CW)
  ) window_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .col_in(col_bus),
    .tag_vld(tag_vld), .tag_idx(tag_idx), .wts(wts_q),
    .res_vld(res_vld), .res_idx(res_idx), .res_data(res_data)
  );

  always_ff @(posedge clk) begin
    if (accept) wts_q <= kernel_in;
  end

  always_ff @(posedge clk) begin
    if (res_vld) obuf_q[IW'(res_idx)] <= res_data;
  end

  assign wr_data = obuf_q[IW'(out_rd_idx)];

  // R7: read request held with stable address until accepted
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R7: write request held with stable address and data until accepted
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6: reads and result writes never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  // R9: done follows a write handshake and lasts one cycle
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready) && !busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/conv3_row_engine_tb_top.sv
module conv3_row_engine_tb_top;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [5:0]   cfg_width;
  logic [7:0]   cfg_height;
  logic [143:0] kernel_in;
  logic         busy, done, cfg_err;
  logic         rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [15:0]  rd_req_addr, rd_rsp_data;
  logic         wr_valid, wr_ready;
  logic [15:0]  wr_addr, wr_data;

  conv3_row_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .kernel_in(kernel_in),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic signed [15:0] img  [0:1023];
  logic signed [15:0] oimg [0:1023];
  int kw [9];
  int n_chk, n_fail;
  int rd_cnt, rd_oob, wr_cnt, order_bad, last_wr, cur_w, cur_h;
  int pend, paddr;
  bit stall_mode;
  logic [15:0] lfsr;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: bookkeeping at the edge
  always @(posedge clk) begin
    if (rd_rsp_valid) pend = 0;
    if (rd_req_valid && rd_req_ready) begin
      pend  = 1;
      paddr = int'(rd_req_addr);
      rd_cnt++;
      if (paddr >= cur_w * cur_h) rd_oob++;
    end
    if (wr_valid && wr_ready) begin
      if (int'(wr_addr) != last_wr + 1) order_bad++;
      last_wr = int'(wr_addr);
      if (wr_addr < 16'd1024) oimg[wr_addr] = wr_data;
      wr_cnt++;
    end
  end

  // memory model: drive on the falling edge
  initial begin
    lfsr = 16'hACE1;
    rd_req_ready = 1'b0;
    wr_ready     = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready = stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
      wr_ready     = stall_mode ? (lfsr[1] | lfsr[7]) : 1'b1;
      rd_rsp_valid = (pend != 0) && (stall_mode ? (lfsr[2] | lfsr[9]) : 1'b1);
      rd_rsp_data  = img[paddr];
    end
  end

  function automatic int expv(input int w, input int h, input int r, input int c);
    longint s = 0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        int rr = r + i - 1;
        int cc = c + j - 1;
        if (rr >= 0 && rr < h && cc >= 0 && cc < w)
          s += longint'(img[rr*w+cc]) * longint'(kw[i*3+j]);
      end
    end
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  function automatic int exp_reads(input int w, input int h);
    int n = 0;
    for (int r = 0; r < h; r++)
      for (int d = -1; d <= 1; d++)
        if (r + d >= 0 && r + d < h) n += w;
    return n;
  endfunction

  task automatic load_kernel();
    for (int k = 0; k < 9; k++) kernel_in[16*k +: 16] = 16'(kw[k]);
  endtask

  task automatic run_case(input int w, input int h, input bit stall, input string tag,
                          input bit disturb);
    int cyc = 0;
    int dones = 0;
    bit seen = 0;
    cur_w = w; cur_h = h;
    rd_cnt = 0; rd_oob = 0; wr_cnt = 0; order_bad = 0; last_wr = -1;
    for (int i = 0; i < 1024; i++) oimg[i] = 16'sh5A5A;
    stall_mode = stall;
    @(negedge clk);
    cfg_width = 6'(w); cfg_height = 8'(h); load_kernel();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      cfg_width = 6'd3; cfg_height = 8'd1;
      kernel_in = {9{16'sd7}};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < 40000 && !seen) begin
      if (done) begin
        seen = 1;
        dones++;
        check(wr_cnt == w*h, "R9 writes before done", wr_cnt, w*h);
        check(busy == 1'b0, "R9 busy low with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(seen, "watchdog per case", seen, 1);
    repeat (20) @(negedge clk);
    if (done) dones++;
    check(dones == 1, "R11 single done", dones, 1);
    check(wr_cnt == w*h, {tag, " write count"}, wr_cnt, w*h);
    check(order_bad == 0, "R6 ascending writes", order_bad, 0);
    check(rd_cnt == exp_reads(w, h), "R5 read count", rd_cnt, exp_reads(w, h));
    check(rd_oob == 0, "R5 read range", rd_oob, 0);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        check(int'(oimg[r*w+c]) == expv(w, h, r, c), tag, int'(oimg[r*w+c]), expv(w, h, r, c));
  endtask

  task automatic fill_img(input int w, input int h, input int seed);
    for (int i = 0; i < w*h; i++) img[i] = 16'((((i * 37 + seed * 101) % 251) - 125) * 9);
  endtask

  task automatic bad_start(input int w, input int h);
    int r0 = rd_cnt;
    @(negedge clk);
    cfg_width = 6'(w); cfg_height = 8'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == 1'b1, "R8 err raised", cfg_err, 1);
    check(busy == 1'b0, "R8 stays idle", busy, 0);
    repeat (5) @(negedge clk);
    check(rd_cnt == r0, "R8 no reads", rd_cnt, r0);
  endtask

  initial begin
    int wl [7] = '{1, 2, 3, 4, 5, 7, 30};
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; cfg_width = '0; cfg_height = '0; kernel_in = '0;
    pend = 0; paddr = 0; stall_mode = 0; cur_w = 1; cur_h = 1;
    rd_cnt = 0; rd_oob = 0; wr_cnt = 0; order_bad = 0; last_wr = -1;
    for (int i = 0; i < 1024; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    check(rd_req_valid == 0, "R1 rd_req_valid", rd_req_valid, 0);
    check(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sweep over sizes, with and without stalls (R7)
    for (int a = 0; a < 7; a++) begin
      for (int h = 1; h <= 5; h++) begin
        for (int k = 0; k < 9; k++) kw[k] = ((k * 13 + a * 5 + h * 3) % 19) - 9;
        fill_img(wl[a], h, a * 7 + h);
        run_case(wl[a], h, (a + h) % 2 == 1, (a + h) % 2 == 1 ? "R7 stalled R2" : "R2", 1'b0);
      end
    end

    // R3 positive and negative saturation
    for (int i = 0; i < 15; i++) img[i] = 16'sh7FFF;
    for (int k = 0; k < 9; k++) kw[k] = 32767;
    run_case(5, 3, 1'b1, "R3 sat high", 1'b0);
    for (int k = 0; k < 9; k++) kw[k] = -32768;
    run_case(5, 3, 1'b0, "R3 sat low", 1'b0);

    // R4 centre-only kernel
    for (int k = 0; k < 9; k++) kw[k] = 0;
    kw[4] = 1;
    fill_img(6, 4, 3);
    run_case(6, 4, 1'b1, "R4 centre", 1'b0);
    kw[4] = -3;
    run_case(6, 4, 1'b0, "R4 centre neg", 1'b0);

    // R10 and R11: config changes and extra start while busy
    for (int k = 0; k < 9; k++) kw[k] = k - 4;
    fill_img(8, 3, 11);
    run_case(8, 3, 1'b1, "R10 latched cfg", 1'b1);

    // R8 refused sizes, then cleared by a good start
    bad_start(31, 2);
    bad_start(0, 2);
    bad_start(4, 0);
    fill_img(4, 2, 5);
    run_case(4, 2, 1'b0, "R8 recovery", 1'b0);
    check(cfg_err == 1'b0, "R8 err cleared", cfg_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule